// File: doc/BRIEF.md
# FIFO Level and Error Interrupt Unit

This unit produces the interrupt for a serial controller that buffers its traffic in a transmit FIFO and a receive FIFO. The FIFOs and the shift engine sit outside the unit. They supply two live fill levels and three single-cycle error pulses: receive overflow, receive underflow and transmit overflow. The unit builds a five-bit raw status vector from these inputs. It keeps a mask register and drives one active-high interrupt line. Software can see the raw status and the masked status.

Two kinds of status bit behave differently. The two level bits are combinational. The receive bit is set while the receive level is above a programmable threshold. The transmit bit is set while the transmit level is at or below a programmable threshold. These bits follow the levels cycle by cycle and nothing latches them. The three error bits are sticky. Each one stays set until software writes to a clear register, which has one write-one-to-clear bit per error and one bit that clears every error at once.

Software reaches the unit through a one-cycle write port that carries a 2-bit select. Select 0 writes the mask. Select 1 writes the receive threshold. Select 2 writes the transmit threshold. Select 3 writes the clear register, which stores nothing.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset the mask and both thresholds are zero. `masked_stat` and `irq` are low. With both levels at zero, `raw_stat` reads 5'b00001.
- R2: The bit positions in `raw_stat`, `masked_stat` and the mask are fixed: bit 4 is receive-above-threshold, bit 3 is receive overflow, bit 2 is receive underflow, bit 1 is transmit overflow and bit 0 is transmit-at-or-below-threshold.
- R3: Bit 4 is 1 exactly when `rx_level` is greater than the receive threshold. A threshold of N-1 therefore fires at N entries.
- R4: Bit 0 is 1 exactly when `tx_level` is less than or equal to the transmit threshold. A threshold of 0 fires only when the transmit FIFO is empty.
- R5: A one-cycle pulse on an error input sets its status bit from the next cycle onward. The bit stays set until it is cleared.
- R6: A clear write (`wr_sel`=3) clears receive overflow with data bit 2, receive underflow with data bit 1 and transmit overflow with data bit 3. A zero in any of these data bits leaves the matching status bit as it was.
- R7: Data bit 0 of a clear write clears all three error bits.
- R8: When an error pulse and a clear of the same bit arrive in the same cycle, the bit stays set.
- R9: A clear write does not change bits 4 and 0.
- R10: `masked_stat` equals `raw_stat` AND mask. `irq` is the OR of `masked_stat`.
- R11: A mask write of zero brings `irq` low from the cycle after the write, whatever the raw status is.
- R12: A write with `wr_sel`=0, 1 or 2 loads the low bits of `wr_data` into the mask, the receive threshold or the transmit threshold. The new value takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 6 | Receive FIFO fill level |
| tx_level | input | 6 | Transmit FIFO fill level |
| rx_ovf_pulse | input | 1 | One-cycle receive overflow event |
| rx_udf_pulse | input | 1 | One-cycle receive underflow event |
| tx_ovf_pulse | input | 1 | One-cycle transmit overflow event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mask, 1 rx threshold, 2 tx threshold, 3 clear |
| wr_data | input | 5 | Write data |
| raw_stat | output | 5 | Unmasked status |
| masked_stat | output | 5 | Status ANDed with mask |
| irq | output | 1 | Interrupt line |

## Verification
A sticky bit that is lost or set by mistake shows on `raw_stat` one cycle after the pulse or clear that caused it. Every later cycle then disagrees with the model until the next clear, so a corrupted error bit cannot hide. A wrong threshold register or a wrong comparison edge shows as soon as the level crosses the boundary. For this reason the directed tests sit exactly at N and N+1 of each threshold. A wrong mask shows on `masked_stat` and `irq` in the cycle after the write. The random phase keeps the mask and the status varying together so that a wrong mask is seen.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
    localparam int STAT_W      = 5;
    localparam int B_TX_LOW    = 0;
    localparam int B_TX_OVF    = 1;
    localparam int B_RX_UDF    = 2;
    localparam int B_RX_OVF    = 3;
    localparam int B_RX_HIGH   = 4;

    // clear-register bit positions
    localparam int C_ALL       = 0;
    localparam int C_RX_UDF    = 1;
    localparam int C_RX_OVF    = 2;
    localparam int C_TX_OVF    = 3;

    localparam int N_STICKY    = 3;

    typedef enum logic [1:0] {
        SEL_MASK   = 2'd0,
        SEL_RX_THR = 2'd1,
        SEL_TX_THR = 2'd2,
        SEL_CLEAR  = 2'd3
    } wsel_e;
endpackage

// File: rtl/fifo_irq_thresh.sv
module fifo_irq_thresh #(
    parameter int LVL_W = 6,
    parameter int THR_W = 5
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [THR_W-1:0] tx_thr,
    output logic             rx_high,
    output logic             tx_low
);
    localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

    logic [CMP_W-1:0] rx_l, tx_l, rx_t, tx_t;

    always_comb begin
        rx_l    = CMP_W'(rx_level);
        tx_l    = CMP_W'(tx_level);
        rx_t    = CMP_W'(rx_thr);
        tx_t    = CMP_W'(tx_thr);
        rx_high = (rx_l >  rx_t);
        tx_low  = (tx_l <= tx_t);
    end
endmodule

// File: rtl/fifo_irq_sticky.sv
module fifo_irq_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr_one,
    input  logic         clr_all,
    output logic [N-1:0] flag_q
);
    logic [N-1:0] flag_d;

    always_comb begin
        flag_d = flag_q;
        for (int i = 0; i < N; i++) begin
            if (evt[i])
                flag_d[i] = 1'b1;
            else if (clr_one[i] || clr_all)
                flag_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> flag_q[g]); // R5
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[g] && !clr_one[g] && !clr_all) |=> $stable(flag_q[g])); // R5
        AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[g] && (clr_one[g] || clr_all)) |=> !flag_q[g]); // R6
    end
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int THR_W = 5,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              rx_ovf_pulse,
    input  logic              rx_udf_pulse,
    input  logic              tx_ovf_pulse,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] raw_stat,
    output logic [STAT_W-1:0] masked_stat,
    output logic              irq
);
    typedef struct packed {
        logic [STAT_W-1:0] mask;
        logic [THR_W-1:0]  rx_thr;
        logic [THR_W-1:0]  tx_thr;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  clr_wr;
    logic  [N_STICKY-1:0] evt_v, clr_v, sticky_q;
    logic  rx_high, tx_low;

    always_comb begin
        regs_d = regs_q;
        clr_wr = 1'b0;
        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_MASK:   regs_d.mask   = wr_data;
                SEL_RX_THR: regs_d.rx_thr = THR_W'(wr_data);
                SEL_TX_THR: regs_d.tx_thr = THR_W'(wr_data);
                default:    clr_wr        = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // sticky order: [0] tx overflow, [1] rx underflow, [2] rx overflow
    always_comb begin
        evt_v = {rx_ovf_pulse, rx_udf_pulse, tx_ovf_pulse};
        clr_v = {clr_wr & wr_data[C_RX_OVF],
                 clr_wr & wr_data[C_RX_UDF],
                 clr_wr & wr_data[C_TX_OVF]};
    end

    fifo_irq_sticky #(.N(N_STICKY)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_v),
        .clr_one(clr_v),
        .clr_all(clr_wr & wr_data[C_ALL]),
        .flag_q (sticky_q)
    );

    fifo_irq_thresh #(.LVL_W(LVL_W), .THR_W(THR_W)) u_thresh (
        .rx_level(rx_level),
        .tx_level(tx_level),
        .rx_thr  (regs_q.rx_thr),
        .tx_thr  (regs_q.tx_thr),
        .rx_high (rx_high),
        .tx_low  (tx_low)
    );

    always_comb begin
        raw_stat            = '0;
        raw_stat[B_RX_HIGH] = rx_high;
        raw_stat[B_RX_OVF]  = sticky_q[2];
        raw_stat[B_RX_UDF]  = sticky_q[1];
        raw_stat[B_TX_OVF]  = sticky_q[0];
        raw_stat[B_TX_LOW]  = tx_low;
        masked_stat         = raw_stat & regs_q.mask;
        irq                 = |masked_stat;
    end

    AST_MASK_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MASK && wr_data == '0) |=> !irq); // R11
    AST_CLEAR_LEVEL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLEAR) |=>
        (!$stable(rx_level) || !$stable(tx_level) ||
         ($stable(raw_stat[B_RX_HIGH]) && $stable(raw_stat[B_TX_LOW])))); // R9
    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_stat != '0)); // R10
endmodule

// File: tb/tb_fifo_irq_unit.sv
module tb_fifo_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] rx_level, tx_level;
    logic       rx_ovf_pulse, rx_udf_pulse, tx_ovf_pulse;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [4:0] wr_data;
    logic [4:0] raw_stat, masked_stat;
    logic       irq;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    logic [4:0] m_mask, m_rxthr, m_txthr;
    logic       m_rxovf, m_rxudf, m_txovf;

    fifo_irq_unit dut (.*);

    always #10 clk = ~clk;

    function automatic logic [4:0] exp_raw();
        return {(rx_level > {1'b0, m_rxthr}), m_rxovf, m_rxudf, m_txovf,
                (tx_level <= {1'b0, m_txthr})};
    endfunction

    task automatic chk(input string tag);
        logic [4:0] er;
        er = exp_raw();
        tests++;
        if (raw_stat !== er) begin
            fails++; $display("FAIL %s raw_stat act=%b exp=%b", tag, raw_stat, er);
        end
        tests++;
        if (masked_stat !== (er & m_mask)) begin
            fails++; $display("FAIL %s masked_stat act=%b exp=%b", tag, masked_stat, er & m_mask);
        end
        tests++;
        if (irq !== |(er & m_mask)) begin
            fails++; $display("FAIL %s irq act=%b exp=%b", tag, irq, |(er & m_mask));
        end
    endtask

    // drive at negedge, model update at posedge, outputs sampled at next negedge
    task automatic cyc(input logic [5:0] rxl, input logic [5:0] txl,
                       input logic [2:0] ev, input logic we,
                       input logic [1:0] sel, input logic [4:0] d);
        rx_level = rxl; tx_level = txl;
        {rx_ovf_pulse, rx_udf_pulse, tx_ovf_pulse} = ev;
        wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        if (we && sel == 2'd3) begin
            if (d[2] || d[0]) m_rxovf = 1'b0;
            if (d[1] || d[0]) m_rxudf = 1'b0;
            if (d[3] || d[0]) m_txovf = 1'b0;
        end
        if (ev[2]) m_rxovf = 1'b1;
        if (ev[1]) m_rxudf = 1'b1;
        if (ev[0]) m_txovf = 1'b1;
        if (we && sel == 2'd0) m_mask  = d;
        if (we && sel == 2'd1) m_rxthr = d;
        if (we && sel == 2'd2) m_txthr = d;
        @(negedge clk);
        {rx_ovf_pulse, rx_udf_pulse, tx_ovf_pulse} = 3'b000;
        wr_en = 1'b0;
    endtask

    task automatic expect_bits(input string tag, input logic [4:0] e);
        tests++;
        if (raw_stat !== e) begin
            fails++; $display("FAIL %s raw_stat act=%b exp=%b", tag, raw_stat, e);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        m_mask = 0; m_rxthr = 0; m_txthr = 0; m_rxovf = 0; m_rxudf = 0; m_txovf = 0;
        rst_n = 1'b0; rx_level = 0; tx_level = 0;
        {rx_ovf_pulse, rx_udf_pulse, tx_ovf_pulse} = 3'b000;
        wr_en = 0; wr_sel = 0; wr_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        expect_bits("R1", 5'b00001);
        chk("R1");

        // R12 / R3: rx threshold 3 -> fires at 4
        cyc(6'd0, 6'd5, 3'b000, 1'b1, 2'd1, 5'd3);
        cyc(6'd3, 6'd5, 3'b000, 1'b0, 2'd0, 5'd0);
        expect_bits("R3 at_thr", 5'b00000); chk("R3");
        cyc(6'd4, 6'd5, 3'b000, 1'b0, 2'd0, 5'd0);
        expect_bits("R3 above", 5'b10000); chk("R12");

        // R4: tx threshold 2
        cyc(6'd0, 6'd2, 3'b000, 1'b1, 2'd2, 5'd2);
        expect_bits("R4 eq", 5'b00001); chk("R4");
        cyc(6'd0, 6'd3, 3'b000, 1'b0, 2'd0, 5'd0);
        expect_bits("R4 above", 5'b00000);

        // R5 / R2: events latch and hold, bit positions
        cyc(6'd0, 6'd3, 3'b100, 1'b0, 2'd0, 5'd0);
        expect_bits("R2 rx_ovf", 5'b01000);
        cyc(6'd0, 6'd3, 3'b010, 1'b0, 2'd0, 5'd0);
        expect_bits("R2 rx_udf", 5'b01100);
        cyc(6'd0, 6'd3, 3'b001, 1'b0, 2'd0, 5'd0);
        expect_bits("R2 tx_ovf", 5'b01110);
        repeat (3) cyc(6'd0, 6'd3, 3'b000, 1'b0, 2'd0, 5'd0);
        expect_bits("R5 hold", 5'b01110); chk("R5");

        // R6 individual clears
        cyc(6'd0, 6'd3, 3'b000, 1'b1, 2'd3, 5'b01000);
        expect_bits("R6 clr tx_ovf", 5'b01100);
        cyc(6'd0, 6'd3, 3'b000, 1'b1, 2'd3, 5'b00100);
        expect_bits("R6 clr rx_ovf", 5'b00100);
        cyc(6'd0, 6'd3, 3'b000, 1'b1, 2'd3, 5'b00010);
        expect_bits("R6 clr rx_udf", 5'b00000); chk("R6");

        // R7 clear all
        cyc(6'd0, 6'd3, 3'b111, 1'b0, 2'd0, 5'd0);
        expect_bits("R7 set", 5'b01110);
        cyc(6'd0, 6'd3, 3'b000, 1'b1, 2'd3, 5'b00001);
        expect_bits("R7 all", 5'b00000); chk("R7");

        // R8 event wins over clear
        cyc(6'd0, 6'd3, 3'b100, 1'b1, 2'd3, 5'b00101);
        expect_bits("R8", 5'b01000); chk("R8");

        // R9 clear leaves level bits alone
        cyc(6'd9, 6'd1, 3'b000, 1'b0, 2'd0, 5'd0);
        expect_bits("R9 pre", 5'b11001);
        cyc(6'd9, 6'd1, 3'b000, 1'b1, 2'd3, 5'b11111);
        expect_bits("R9", 5'b10001); chk("R9");

        // R10 / R11 mask
        cyc(6'd9, 6'd1, 3'b011, 1'b1, 2'd0, 5'b11111);
        chk("R10");
        tests++;
        if (irq !== 1'b1) begin fails++; $display("FAIL R10 irq act=%b exp=1", irq); end
        cyc(6'd9, 6'd1, 3'b000, 1'b1, 2'd0, 5'b00000);
        tests++;
        if (irq !== 1'b0 || masked_stat !== 5'b0) begin
            fails++; $display("FAIL R11 irq act=%b masked=%b exp=0", irq, masked_stat);
        end
        chk("R11");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] rl, tl;
            logic [2:0] ev;
            logic       we;
            logic [1:0] s;
            logic [4:0] d;
            rl = 6'($urandom_range(0, 32));
            tl = 6'($urandom_range(0, 32));
            ev = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            we = ($urandom_range(0, 2) == 0);
            s  = 2'($urandom);
            d  = 5'($urandom);
            cyc(rl, tl, ev, we, s, d);
            chk("R10 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule